// File: doc/BRIEF.md
# Buffered UART Register Front End

This block is the processor-facing half of a fixed 8N1 UART. A simple word-addressed register port gives software five registers. Through them it can push bytes into a 64-entry transmit queue, pop tagged bytes from a 64-entry receive queue, watch queue occupancy, set trigger levels and flow control, and service interrupt causes. The bit-serial line engine is a separate block. It takes transmit bytes through a valid/ready pair and delivers received bytes, with their framing and break flags, as one-cycle strobes. It also gives one pulse per character time, which drives the inactivity timeout. The block passes the baud divider and the forced-break request back to the engine.

Software usually sets trigger levels and enables in the control register. It fills the transmit queue until the transmit request cause fires. It drains the receive queue when the receive trigger or the inactivity timeout cause fires. The single interrupt line is the OR of every cause whose group enable is set. Latched causes stay set until software writes a one to their bit. Level causes follow the queue state.

Top module: `uart_fifo_regs`

## Requirements
- R1: Registers sit at byte offsets 0x00 data, 0x04 level, 0x08 status, 0x0C control and 0x10 rate. After reset, level, status, control and rate read 0, and irq, tx_valid and break_out are low. Only control bits 8:0 and 21:14 are stored, so a write of all ones reads back 0x003FC1FF. The rate register keeps wdata bits 7:0 and drives rate_div.
- R2: A data read returns the byte in bits 7:0, the framing tag in bit 9 and the break tag in bit 10, and pops that entry. When the receive queue is empty the read returns 0x100 and pops nothing.
- R3: The level register holds the transmit count in bits 15:8 and the receive count in bits 7:0. Both queues are first-in first-out. A data write to a full transmit queue (64 entries) is dropped.
- R4: Status bit 1 is high while the receive count is at or above the level chosen by control bits 4:2. Codes 0 to 5 select 1, 4, 8, 16, 32 and 48, and codes 6 and 7 select 48.
- R5: Status bit 0 latches when an engine pop brings the transmit count down to the level chosen by control bits 1:0. Codes 0 to 3 select 0, 4, 8 and 16. The bit also latches when software writes 1 to status bit 6. Status bit 6 reads 0.
- R6: Control bits 17:16 select the timeout: 0 means off, and 1, 2 and 3 mean 4, 8 and 16 char_tick pulses. Status bit 2 goes high once that many pulses have passed with no receive strobe and no pop while the receive queue holds data. It drops when a byte is popped.
- R7: Status bit 3 latches on a stored byte with the framing flag, and bit 4 latches on a stored byte with the break flag. Writing 1 to a latched bit (0, 3, 4 or 5) clears only that bit, and a new event in the same cycle wins.
- R8: A receive strobe while the receive queue is full discards the byte and latches status bit 5.
- R9: irq is high when status bit 0 is set and control bit 5 is set, or when status bit 1 or 2 is set and control bit 6 is set, or when any of status bits 3 to 5 is set and control bit 7 is set.
- R10: tx_valid is high only when the transmit queue is not empty and control bit 8 is clear. When control bit 14 is set, cts_in XOR control bit 15 must also be 1. break_out follows control bit 8.
- R11: With control bit 18 set, rts_out is 1 while the receive count is below the level chosen by bits 20:19 (8, 16, 32 or 48), and 0 otherwise. With bit 18 clear the pre-inversion value is 1. Control bit 21 inverts the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| sel | input | 1 | register access strobe, one cycle |
| wr | input | 1 | 1 write, 0 read |
| addr | input | 5 | byte offset |
| wdata | input | 32 | write data |
| rdata | output | 32 | read data for the current address |
| tx_data | output | 8 | byte offered to the line engine |
| tx_valid | output | 1 | a transmit byte is offered |
| tx_ready | input | 1 | engine takes the byte |
| rx_data | input | 8 | received byte |
| rx_ferr | input | 1 | framing error flag for rx_data |
| rx_brk | input | 1 | break flag for rx_data |
| rx_valid | input | 1 | one-cycle receive strobe |
| char_tick | input | 1 | one pulse per character time |
| cts_in | input | 1 | clear-to-send pin |
| rts_out | output | 1 | request-to-send pin |
| break_out | output | 1 | force line break |
| rate_div | output | 8 | baud divider to engine |
| irq | output | 1 | interrupt request |

## Verification
The bench fills the transmit queue past 64 entries and checks that the extra writes vanish and are not sent later. A design that wrapped its pointer would resend or lose earlier bytes. It drives the transmit count down one pop at a time toward the trigger, so a request that fired one entry early or late is caught. A request tested on level alone would also show up, because it could not be cleared. On receive, it overflows the queue by one byte and reads the queue while it is empty. A design that popped on an empty read would corrupt the count, and one that stored the overflow byte would break the order. It also counts timeout pulses one short of the limit and then at the limit, and it toggles the CTS and RTS inversions to catch a polarity that is swapped.

// File: rtl/uart_fifo_regs.sv
module uart_fifo_regs #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        wr,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_ferr,
  input  logic        rx_brk,
  input  logic        rx_valid,
  input  logic        char_tick,
  input  logic        cts_in,
  output logic        rts_out,
  output logic        break_out,
  output logic [7:0]  rate_div,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [31:0] CTRL_MASK = 32'h003F_C1FF;

  logic [7:0]    tx_mem [DEPTH];
  logic [9:0]    rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt, tx_next;
  logic [31:0]   ctrl_q;
  logic [7:0]    rate_q;
  logic          req_q, fe_q, brk_q, ovr_q;
  logic [4:0]    idle_cnt;
  logic [CW-1:0] rx_trig_lvl, tx_trig_lvl, rts_lvl;
  logic [4:0]    tmo_lvl;

  wire [2:0] widx    = addr[4:2];
  wire acc_data      = sel && widx == 3'd0;
  wire wr_sts        = sel && wr && widx == 3'd2;
  wire tx_push       = acc_data && wr && tx_cnt != FULL;
  wire tx_pop        = tx_valid && tx_ready;
  wire rx_push       = rx_valid && rx_cnt != FULL;
  wire rx_pop        = acc_data && !wr && rx_cnt != 0;
  wire cts_ok        = !ctrl_q[14] || (cts_in ^ ctrl_q[15]);

  assign tx_valid  = tx_cnt != 0 && cts_ok && !ctrl_q[8];
  assign tx_data   = tx_mem[tx_rp];
  assign break_out = ctrl_q[8];
  assign rate_div  = rate_q;
  assign tx_next   = tx_cnt + CW'(tx_push) - CW'(tx_pop);

  always_comb begin
    case (ctrl_q[4:2])
      3'd0: rx_trig_lvl = CW'(1);
      3'd1: rx_trig_lvl = CW'(4);
      3'd2: rx_trig_lvl = CW'(8);
      3'd3: rx_trig_lvl = CW'(16);
      3'd4: rx_trig_lvl = CW'(32);
      default: rx_trig_lvl = CW'(48);
    endcase
    case (ctrl_q[1:0])
      2'd0: tx_trig_lvl = CW'(0);
      2'd1: tx_trig_lvl = CW'(4);
      2'd2: tx_trig_lvl = CW'(8);
      default: tx_trig_lvl = CW'(16);
    endcase
    case (ctrl_q[20:19])
      2'd0: rts_lvl = CW'(8);
      2'd1: rts_lvl = CW'(16);
      2'd2: rts_lvl = CW'(32);
      default: rts_lvl = CW'(48);
    endcase
    case (ctrl_q[17:16])
      2'd1: tmo_lvl = 5'd4;
      2'd2: tmo_lvl = 5'd8;
      default: tmo_lvl = 5'd16;
    endcase
  end

  wire rx_trig = rx_cnt >= rx_trig_lvl;
  wire tmo_hit = ctrl_q[17:16] != 2'd0 && rx_cnt != 0 && idle_cnt >= tmo_lvl;
  wire [6:0] sts = {1'b0, ovr_q, brk_q, fe_q, tmo_hit, rx_trig, req_q};

  assign rts_out = (!ctrl_q[18] || rx_cnt < rts_lvl) ^ ctrl_q[21];
  assign irq = (ctrl_q[5] && sts[0]) || (ctrl_q[6] && |sts[2:1]) ||
               (ctrl_q[7] && |sts[5:3]);

  always_comb begin
    case (widx)
      3'd0: rdata = rx_cnt == 0 ? 32'h100
                  : {21'd0, rx_mem[rx_rp][9:8], 1'b0, rx_mem[rx_rp][7:0]};
      3'd1: rdata = {16'd0, 8'(tx_cnt), 8'(rx_cnt)};
      3'd2: rdata = {25'd0, sts};
      3'd3: rdata = ctrl_q;
      3'd4: rdata = {24'd0, rate_q};
      default: rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= wdata[7:0];
    if (rx_push) rx_mem[rx_wp] <= {rx_brk, rx_ferr, rx_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      tx_cnt <= tx_next;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rate_q <= '0;
    end else if (sel && wr) begin
      if (widx == 3'd3) ctrl_q <= wdata & CTRL_MASK;
      if (widx == 3'd4) rate_q <= wdata[7:0];
    end
  end

  wire req_set = (tx_pop && tx_cnt > tx_trig_lvl && tx_next <= tx_trig_lvl) ||
                 (wr_sts && wdata[6]);
  wire fe_set  = rx_push && rx_ferr;
  wire brk_set = rx_push && rx_brk;
  wire ovr_set = rx_valid && rx_cnt == FULL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0; fe_q <= 1'b0; brk_q <= 1'b0; ovr_q <= 1'b0;
    end else begin
      req_q <= req_set || (req_q && !(wr_sts && wdata[0]));
      fe_q  <= fe_set  || (fe_q  && !(wr_sts && wdata[3]));
      brk_q <= brk_set || (brk_q && !(wr_sts && wdata[4]));
      ovr_q <= ovr_set || (ovr_q && !(wr_sts && wdata[5]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idle_cnt <= '0;
    else if (rx_valid || rx_pop || rx_cnt == 0)
      idle_cnt <= '0;
    else if (char_tick && idle_cnt != 5'd16)
      idle_cnt <= idle_cnt + 1'b1;
  end
endmodule

module uart_fifo_regs_chk #(
  parameter int DEPTH = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       wr,
  input logic [2:0] widx,
  input logic       rx_valid,
  input logic       tx_valid,
  input logic       break_out,
  input logic       irq,
  input logic [6:0] tx_lvl,
  input logic [6:0] rx_lvl,
  input logic [31:0] ctrl,
  input logic [6:0] sts
);
  // R3
  lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lvl <= 7'(DEPTH) && rx_lvl <= 7'(DEPTH));
  // R2
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel && !wr && widx == 3'd0 && rx_lvl == 0 && !rx_valid |=> rx_lvl == 0);
  // R8
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_lvl == 7'(DEPTH) |=> sts[5] && rx_lvl == 7'(DEPTH));
  // R10
  break_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    break_out |-> !tx_valid);
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl[5] || ctrl[6] || ctrl[7]));
endmodule

bind uart_fifo_regs uart_fifo_regs_chk #(.DEPTH(DEPTH)) chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .widx(addr[4:2]),
  .rx_valid(rx_valid), .tx_valid(tx_valid), .break_out(break_out), .irq(irq),
  .tx_lvl(tx_cnt), .rx_lvl(rx_cnt), .ctrl(ctrl_q), .sts(sts)
);

// File: tb/tb_uart_fifo_regs.sv
module tb_uart_fifo_regs;
  logic clk = 0, rst_n = 0;
  logic sel = 0, wr = 0;
  logic [4:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [7:0] tx_data, rx_data = 0, rate_div;
  logic tx_valid, tx_ready = 0, rx_ferr = 0, rx_brk = 0, rx_valid = 0;
  logic char_tick = 0, cts_in = 0, rts_out, break_out, irq;
  int total = 0, bad = 0, tx_model = 0, rx_model = 0;
  bit done = 0;
  logic [7:0]  tx_q[$];
  logic [31:0] rx_q[$];

  always #5 clk = ~clk;

  uart_fifo_regs dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%h exp=%h", req, act, exp); end
  endtask

  task automatic bwrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bread(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a; #1 d = rdata;
    @(negedge clk); sel = 0;
  endtask

  task automatic expect_reg(input logic [4:0] a, input logic [31:0] e, input string req);
    logic [31:0] d;
    bread(a, d);
    check(d === e, req, d, e);
  endtask

  task automatic tx_put(input logic [7:0] b);
    bwrite(5'h00, {24'd0, b});
    if (tx_model < 64) begin tx_q.push_back(b); tx_model++; end
  endtask

  task automatic tx_take(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tx_ready = 1;
      @(negedge clk); tx_ready = 0;
    end
  endtask

  task automatic rx_send(input logic [7:0] b, input logic fe, input logic bk);
    @(negedge clk); rx_valid = 1; rx_data = b; rx_ferr = fe; rx_brk = bk;
    @(negedge clk); rx_valid = 0;
    if (rx_model < 64) begin rx_q.push_back({21'd0, bk, fe, 1'b0, b}); rx_model++; end
  endtask

  task automatic rx_drain(input string req);
    logic [31:0] d;
    forever begin
      bread(5'h00, d);
      if (d[8]) break;
      if (rx_q.size() == 0) check(0, req, d, 32'h100);
      else check(d === rx_q[0], req, d, rx_q[0]);
      if (rx_q.size() != 0) void'(rx_q.pop_front());
    end
    check(rx_q.size() == 0 && d === 32'h100, req, d, 32'h100);
    rx_model = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); char_tick = 1;
      @(negedge clk); char_tick = 0;
    end
  endtask

  // transmit monitor: pops the expected queue on each handshake
  initial forever begin
    @(negedge clk); #2;
    if (tx_valid && tx_ready) begin
      if (tx_q.size() == 0) check(0, "R3", {24'd0, tx_data}, 32'hx);
      else begin
        check(tx_data === tx_q[0], "R3", {24'd0, tx_data}, {24'd0, tx_q[0]});
        void'(tx_q.pop_front());
        tx_model--;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    check(irq === 0 && tx_valid === 0 && break_out === 0, "R1", {irq, tx_valid, break_out}, 0);
    expect_reg(5'h04, 0, "R1");
    expect_reg(5'h08, 0, "R1");
    expect_reg(5'h0C, 0, "R1");
    expect_reg(5'h10, 0, "R1");
    expect_reg(5'h00, 32'h100, "R2");
    bwrite(5'h0C, 32'hFFFF_FFFF);
    expect_reg(5'h0C, 32'h003F_C1FF, "R1");
    bwrite(5'h0C, 0);
    bwrite(5'h10, 32'h1AB);
    expect_reg(5'h10, 32'hAB, "R1");
    check(rate_div === 8'hAB, "R1", rate_div, 8'hAB);

    // R3 overflow of the transmit queue
    for (int i = 0; i < 70; i++) tx_put(8'(i * 3 + 1));
    expect_reg(5'h04, 32'h4000, "R3");
    @(negedge clk); tx_ready = 1;
    repeat (80) @(negedge clk);
    tx_ready = 0;
    expect_reg(5'h04, 0, "R3");
    check(tx_q.size() == 0, "R3", tx_q.size(), 0);

    // R5 transmit request latch at trigger 8
    expect_reg(5'h08, 32'h01, "R5");
    bwrite(5'h08, 32'h01);
    expect_reg(5'h08, 0, "R7");
    bwrite(5'h0C, 32'h2);
    for (int i = 0; i < 10; i++) tx_put(8'h80 + 8'(i));
    tx_take(1);
    expect_reg(5'h08, 0, "R5");
    tx_take(1);
    expect_reg(5'h08, 32'h01, "R5");
    bwrite(5'h08, 32'h01);
    expect_reg(5'h08, 0, "R5");
    bwrite(5'h08, 32'h40);
    expect_reg(5'h08, 32'h01, "R5");
    bwrite(5'h0C, 32'h22);
    #1 check(irq === 1, "R9", irq, 1);
    bwrite(5'h08, 32'h01);
    #1 check(irq === 0, "R9", irq, 0);

    // R10 CTS gating, inversion and break
    cts_in = 0;
    bwrite(5'h0C, 32'h4022);
    #1 check(tx_valid === 0, "R10", tx_valid, 0);
    @(negedge clk); cts_in = 1; #1 check(tx_valid === 1, "R10", tx_valid, 1);
    bwrite(5'h0C, 32'hC022);
    #1 check(tx_valid === 0, "R10", tx_valid, 0);
    @(negedge clk); cts_in = 0; #1 check(tx_valid === 1, "R10", tx_valid, 1);
    bwrite(5'h0C, 32'h122);
    #1 check(tx_valid === 0 && break_out === 1, "R10", {tx_valid, break_out}, 1);
    bwrite(5'h0C, 0);
    @(negedge clk); tx_ready = 1;
    repeat (12) @(negedge clk);
    tx_ready = 0;
    check(tx_q.size() == 0, "R3", tx_q.size(), 0);

    // R4 receive trigger at 4, R7 tags, R2 order
    bwrite(5'h08, 32'h3F);
    bwrite(5'h0C, 32'h04);
    rx_send(8'h11, 0, 0);
    rx_send(8'h22, 1, 0);
    rx_send(8'h33, 0, 1);
    expect_reg(5'h08, 32'h18, "R4");
    expect_reg(5'h04, 32'h03, "R3");
    rx_send(8'h44, 0, 0);
    expect_reg(5'h08, 32'h1A, "R4");
    bwrite(5'h0C, 32'h44);
    #1 check(irq === 1, "R9", irq, 1);
    rx_drain("R2");
    expect_reg(5'h00, 32'h100, "R2");
    expect_reg(5'h04, 0, "R2");
    expect_reg(5'h08, 32'h18, "R4");
    bwrite(5'h08, 32'h08);
    expect_reg(5'h08, 32'h10, "R7");
    bwrite(5'h08, 32'h10);
    expect_reg(5'h08, 0, "R7");

    // R8 overrun
    bwrite(5'h0C, 0);
    for (int i = 0; i < 65; i++) rx_send(8'(i + 5), 0, 0);
    expect_reg(5'h04, 32'h40, "R8");
    expect_reg(5'h08, 32'h22, "R8");
    bwrite(5'h0C, 32'h80);
    #1 check(irq === 1, "R9", irq, 1);
    rx_drain("R8");
    bwrite(5'h08, 32'h20);
    expect_reg(5'h08, 0, "R8");

    // R6 inactivity timeout of 4 character times
    bwrite(5'h0C, 32'h10000);
    rx_send(8'h5A, 0, 0);
    tick(3);
    expect_reg(5'h08, 32'h02, "R6");
    tick(1);
    expect_reg(5'h08, 32'h06, "R6");
    rx_drain("R6");
    expect_reg(5'h08, 0, "R6");
    bwrite(5'h0C, 0);
    rx_send(8'hA5, 0, 0);
    tick(20);
    expect_reg(5'h08, 32'h02, "R6");
    rx_drain("R6");

    // R11 RTS at 8 entries
    bwrite(5'h0C, 32'h40000);
    #1 check(rts_out === 1, "R11", rts_out, 1);
    for (int i = 0; i < 7; i++) rx_send(8'(i), 0, 0);
    #1 check(rts_out === 1, "R11", rts_out, 1);
    rx_send(8'h07, 0, 0);
    #1 check(rts_out === 0, "R11", rts_out, 0);
    bwrite(5'h0C, 32'h240000);
    #1 check(rts_out === 1, "R11", rts_out, 1);
    rx_drain("R11");
    #1 check(rts_out === 0, "R11", rts_out, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule